// File: doc/BRIEF.md
# Power Stage Fault Supervisor

A synchronous protection controller for a switching power stage made of four half-bridges. It reads digital flags from external comparators: an overcurrent flag per half-bridge, an unsigned junction temperature code, undervoltage flags for the regulator rail and for each gate-drive rail, and an active-low stage reset. From these it drives a per-bridge enable, a cycle-by-cycle current-limit strobe, an over-temperature warning, an active-low fault output and a weak-pulldown enable.

Three fault policies run side by side. Overcurrent first limits current within the switching period and escalates to a latched shutdown when it persists across consecutive PWM frames. Temperature raises a warning at a lower code and a latched shutdown at a higher code. Undervoltage shuts the stage down for as long as any flag is present and then recovers by itself. The stage reset passes through a two-flop synchronizer. Its low level masks every fault and holds the bridges off. Its level clears the thermal latch, and its rising edge clears the overcurrent latch. The bridge mode (bridge-tied or single-ended) is a static input.

Top module: `pstage_fault_sup`

## Requirements
- R1: While the bridges are enabled, `ilim_o` is high in every cycle in which any bit of `oc_i` is high, and it does so in that same cycle. A momentary overcurrent does not disable the bridges.
- R2: A PWM frame ends in each cycle that has `frame_i` high, and it covers the cycles since the previous strobe, including that strobe cycle. When an overcurrent is seen in 4 consecutive frames, the stage shuts down: every bit of `hb_en_o` is 0 and `fault_no` is 0 from the clock edge of the 4th strobe onward. A frame with no overcurrent restarts the count.
- R3: Overcurrent handling is pooled. A persistent overcurrent on any single half-bridge disables all four.
- R4: A latched overcurrent shutdown stays in place until a rising edge on the synchronized `stage_rst_ni`. After `stage_rst_ni` rises, the bridges re-enable on the 3rd clock edge.
- R5: `otw_o` is high one cycle after `temp_i` exceeds 125 and is low for codes of 125 or below.
- R6: A `temp_i` code above 150 latches a thermal shutdown (all bridges off, `fault_no` = 0). A code of exactly 150 does not. The latch persists after the temperature falls and clears only while the synchronized stage reset is low.
- R7: Any of `uv_reg_i`, `uv_gate_i[0]` or `uv_gate_i[1]` high disables all bridges and drives `fault_no` low in the same cycle. Operation resumes by itself once all three are low.
- R8: From the 2nd clock edge after `stage_rst_ni` goes low, all bridges are off and `fault_no` is 1, whatever faults are stored or present.
- R9: `pulldown_o` is 1 exactly while the synchronized stage reset is low and `btl_mode_i` is 1. With `btl_mode_i` at 0 it is always 0.
- R10: When several faults overlap, the bridges stay off until every latched fault is cleared and every undervoltage flag is gone.
- R11: `hb_en_o` bit i is 1 when half-bridge i switches and 0 when it is in high impedance. All bits always carry the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low system reset |
| stage_rst_ni | input | 1 | Asynchronous active-low stage reset, synchronized inside |
| btl_mode_i | input | 1 | 1 = bridge-tied load, 0 = single-ended |
| frame_i | input | 1 | PWM frame end strobe |
| oc_i | input | NUM_HB | Overcurrent flag per half-bridge |
| temp_i | input | TEMP_W | Unsigned junction temperature code |
| uv_reg_i | input | 1 | Regulator rail undervoltage |
| uv_gate_i | input | NUM_GATE | Gate-drive rail undervoltage flags |
| hb_en_o | output | NUM_HB | Per-bridge enable, 0 = high impedance |
| ilim_o | output | 1 | Cycle-by-cycle current-limit strobe |
| otw_o | output | 1 | Over-temperature warning |
| fault_no | output | 1 | Active-low fault |
| pulldown_o | output | 1 | Weak-pulldown enable |

## Verification
The bench builds the block with its default parameters: four half-bridges, an 8-bit temperature code with thresholds 125 and 150, and a persistence count of 4 frames. With these values the test sequences can place codes right at each threshold and one step above it. They can also reach both sides of the persistence limit in a few frames: three hits, one miss, three hits stays enabled, and one more hit shuts down. Two gate rails make it possible to check each undervoltage flag on its own.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
  typedef struct packed {
    logic oc;
    logic ot;
    logic uv;
  } fault_t;

  localparam int unsigned SYNC_DEPTH = 2;
endpackage

// File: rtl/pfs_rst_sync.sv
module pfs_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_ni,
  output logic level_o,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_ni};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign level_o = sync_q[STAGES-1];
  assign rise_o  = level_o & ~prev_q;

  assert_rise_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/pfs_oc_guard.sv
module pfs_oc_guard #(
  parameter int unsigned NUM_HB    = 4,
  parameter int unsigned OC_FRAMES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              rise_i,
  input  logic              frame_i,
  input  logic [NUM_HB-1:0] oc_i,
  output logic              latch_o
);
  localparam int unsigned CW = $clog2(OC_FRAMES + 1);
  localparam logic [CW-1:0] LAST = CW'(OC_FRAMES - 1);

  logic [CW-1:0] cnt_q;
  logic          seen_q;
  logic          latch_q;
  logic          hit;

  // a frame is hit if any bridge flagged in any of its cycles
  assign hit = seen_q | (|oc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      seen_q  <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      if (rise_i) latch_q <= 1'b0;
      if (!run_i) begin
        cnt_q  <= '0;
        seen_q <= 1'b0;
      end else if (frame_i) begin
        seen_q <= 1'b0;
        if (hit) begin
          if (cnt_q == LAST) begin
            latch_q <= 1'b1;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end else begin
          cnt_q <= '0;
        end
      end else if (|oc_i) begin
        seen_q <= 1'b1;
      end
    end
  end

  assign latch_o = latch_q;

  assert_latch_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_q && !rise_i |=> latch_q);
  assert_cnt_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(OC_FRAMES));
  assert_idle_no_count_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_q == '0);
endmodule

// File: rtl/pfs_thermal.sv
module pfs_thermal #(
  parameter int unsigned TEMP_W    = 8,
  parameter int unsigned WARN_CODE = 125,
  parameter int unsigned SHUT_CODE = 150
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [TEMP_W-1:0] temp_i,
  output logic              warn_o,
  output logic              latch_o
);
  localparam logic [TEMP_W-1:0] WARN_T = TEMP_W'(WARN_CODE);
  localparam logic [TEMP_W-1:0] SHUT_T = TEMP_W'(SHUT_CODE);

  logic warn_q;
  logic latch_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      warn_q  <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      warn_q <= temp_i > WARN_T;
      if (!run_i)               latch_q <= 1'b0;
      else if (temp_i > SHUT_T) latch_q <= 1'b1;
    end
  end

  assign warn_o  = warn_q;
  assign latch_o = latch_q;

  assert_latch_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_q && run_i |=> latch_q);
  assert_masked_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !latch_q);
endmodule

// File: rtl/pstage_fault_sup.sv
module pstage_fault_sup
  import pfs_pkg::*;
#(
  parameter int unsigned NUM_HB    = 4,
  parameter int unsigned NUM_GATE  = 2,
  parameter int unsigned TEMP_W    = 8,
  parameter int unsigned WARN_CODE = 125,
  parameter int unsigned SHUT_CODE = 150,
  parameter int unsigned OC_FRAMES = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                stage_rst_ni,
  input  logic                btl_mode_i,
  input  logic                frame_i,
  input  logic [NUM_HB-1:0]   oc_i,
  input  logic [TEMP_W-1:0]   temp_i,
  input  logic                uv_reg_i,
  input  logic [NUM_GATE-1:0] uv_gate_i,
  output logic [NUM_HB-1:0]   hb_en_o,
  output logic                ilim_o,
  output logic                otw_o,
  output logic                fault_no,
  output logic                pulldown_o
);
  logic   run;
  logic   rise;
  logic   any_fault;
  logic   hiz;
  fault_t flt;

  pfs_rst_sync #(.STAGES(SYNC_DEPTH)) u_rst_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_ni(stage_rst_ni),
    .level_o (run),
    .rise_o  (rise)
  );

  pfs_oc_guard #(.NUM_HB(NUM_HB), .OC_FRAMES(OC_FRAMES)) u_oc_guard (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .rise_i (rise),
    .frame_i(frame_i),
    .oc_i   (oc_i),
    .latch_o(flt.oc)
  );

  pfs_thermal #(.TEMP_W(TEMP_W), .WARN_CODE(WARN_CODE), .SHUT_CODE(SHUT_CODE)) u_thermal (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .temp_i (temp_i),
    .warn_o (otw_o),
    .latch_o(flt.ot)
  );

  // undervoltage is level-sensitive and unregistered: immediate off, auto resume
  assign flt.uv    = uv_reg_i | (|uv_gate_i);
  assign any_fault = |flt;
  assign hiz       = ~run | any_fault;

  for (genvar i = 0; i < NUM_HB; i++) begin : g_hb
    assign hb_en_o[i] = ~hiz;
  end

  assign ilim_o     = (|oc_i) & ~hiz;
  assign fault_no   = ~run | ~any_fault;
  assign pulldown_o = ~run & btl_mode_i;

  assert_uv_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uv_reg_i || uv_gate_i != '0) |-> hb_en_o == '0);
  assert_mask_fault_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulldown_o |-> fault_no && hb_en_o == '0);
  assert_se_no_pd_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !btl_mode_i |-> !pulldown_o);
  assert_ilim_live_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ilim_o |-> hb_en_o == '1);
  assert_uniform_en_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hb_en_o == '0 || hb_en_o == '1);
  assert_fault_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fault_no |-> hb_en_o == '0);
endmodule

// File: tb/pstage_fault_sup_bench.sv
module pstage_fault_sup_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       stage_rst_ni = 1'b0;
  logic       btl_mode_i = 1'b1;
  logic       frame_i = 1'b0;
  logic [3:0] oc_i = '0;
  logic [7:0] temp_i = 8'd20;
  logic       uv_reg_i = 1'b0;
  logic [1:0] uv_gate_i = '0;
  logic [3:0] hb_en_o;
  logic       ilim_o, otw_o, fault_no, pulldown_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  pstage_fault_sup u_pstage_fault_sup (
    .clk_i, .rst_ni, .stage_rst_ni, .btl_mode_i, .frame_i, .oc_i, .temp_i,
    .uv_reg_i, .uv_gate_i, .hb_en_o, .ilim_o, .otw_o, .fault_no, .pulldown_o
  );

  typedef struct packed {
    logic [7:0] temp;
    logic       uvr;
    logic [1:0] uvg;
    logic       otw;
    logic [3:0] en;
    logic       fno;
  } vec_t;

  localparam vec_t VEC [0:8] = '{
    '{8'd20,  1'b0, 2'b00, 1'b0, 4'hF, 1'b1},
    '{8'd125, 1'b0, 2'b00, 1'b0, 4'hF, 1'b1},
    '{8'd126, 1'b0, 2'b00, 1'b1, 4'hF, 1'b1},
    '{8'd150, 1'b0, 2'b00, 1'b1, 4'hF, 1'b1},
    '{8'd60,  1'b1, 2'b00, 1'b0, 4'h0, 1'b0},
    '{8'd60,  1'b0, 2'b01, 1'b0, 4'h0, 1'b0},
    '{8'd60,  1'b0, 2'b10, 1'b0, 4'h0, 1'b0},
    '{8'd130, 1'b1, 2'b11, 1'b1, 4'h0, 1'b0},
    '{8'd60,  1'b0, 2'b00, 1'b0, 4'hF, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  // one frame of one cycle with the given overcurrent mask
  task automatic frame(input logic [3:0] m);
    oc_i = m;
    frame_i = 1'b1;
    #1;
    if (m != 0 && hb_en_o == 4'hF) check("R1 ilim", ilim_o, 1);
    @(negedge clk_i);
    frame_i = 1'b0;
    oc_i = '0;
  endtask

  task automatic stage_pulse();
    stage_rst_ni = 1'b0;
    cyc(3);
    stage_rst_ni = 1'b1;
    cyc(3);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(2);
    rst_ni = 1'b1;
    cyc(1);
    // reset state: stage reset still low
    check("R8 reset en", hb_en_o, 4'h0);
    check("R8 reset fault", fault_no, 1);
    check("R9 btl pd", pulldown_o, 1);
    stage_rst_ni = 1'b1;
    cyc(1);
    check("R8 sync one edge", hb_en_o, 4'h0);
    cyc(1);
    check("R11 run en", hb_en_o, 4'hF);
    check("R9 pd off", pulldown_o, 0);

    // vector walk: temperature thresholds and undervoltage
    foreach (VEC[i]) begin
      temp_i = VEC[i].temp;
      uv_reg_i = VEC[i].uvr;
      uv_gate_i = VEC[i].uvg;
      #1;
      check($sformatf("R7 vec%0d en", i), hb_en_o, VEC[i].en);
      check($sformatf("R7 vec%0d fault", i), fault_no, VEC[i].fno);
      cyc(1);
      check($sformatf("R5 vec%0d otw", i), otw_o, VEC[i].otw);
    end

    // R1: momentary overcurrent, no frame strobe
    oc_i = 4'b0100;
    #1;
    check("R1 ilim immediate", ilim_o, 1);
    check("R1 still enabled", hb_en_o, 4'hF);
    cyc(1);
    oc_i = '0;
    #1;
    check("R1 ilim drops", ilim_o, 0);

    // R2: 3 hits, miss, 3 hits stays enabled; 4th consecutive shuts down (R3 single bridge)
    cyc(1);
    frame(4'b0001); frame(4'b0001); frame(4'b0001);
    frame(4'b0000);
    frame(4'b0001); frame(4'b0001); frame(4'b0001);
    check("R2 count restart", hb_en_o, 4'hF);
    // oc in mid-frame, strobe without flag still counts the frame
    oc_i = 4'b0001; cyc(1); oc_i = '0;
    frame(4'b0000);
    check("R3 all off", hb_en_o, 4'h0);
    check("R2 fault low", fault_no, 0);
    cyc(10);
    check("R4 latch persists", hb_en_o, 4'h0);
    // R8: reset low masks fault
    stage_rst_ni = 1'b0;
    cyc(2);
    check("R8 masked fault", fault_no, 1);
    check("R8 masked en", hb_en_o, 4'h0);
    stage_rst_ni = 1'b1;
    cyc(2);
    check("R4 before clear", hb_en_o, 4'h0);
    cyc(1);
    check("R4 rise clears", hb_en_o, 4'hF);
    check("R4 fault high", fault_no, 1);

    // R6: thermal latch
    temp_i = 8'd151;
    cyc(1);
    check("R6 shut", hb_en_o, 4'h0);
    check("R6 fault", fault_no, 0);
    temp_i = 8'd40;
    cyc(5);
    check("R6 persists", hb_en_o, 4'h0);
    stage_pulse();
    check("R6 cleared", hb_en_o, 4'hF);

    // R10: thermal latch plus undervoltage
    temp_i = 8'd200;
    uv_gate_i = 2'b01;
    cyc(1);
    temp_i = 8'd40;
    uv_gate_i = 2'b00;
    cyc(1);
    check("R10 latch outlasts uv", hb_en_o, 4'h0);
    stage_rst_ni = 1'b0;
    cyc(3);
    uv_reg_i = 1'b1;
    stage_rst_ni = 1'b1;
    cyc(3);
    check("R10 uv holds after clear", hb_en_o, 4'h0);
    uv_reg_i = 1'b0;
    #1;
    check("R10 all clear", hb_en_o, 4'hF);

    // R9: single-ended mode never pulls down
    btl_mode_i = 1'b0;
    stage_rst_ni = 1'b0;
    cyc(3);
    check("R9 se pd", pulldown_o, 0);
    check("R8 se en", hb_en_o, 4'h0);
    stage_rst_ni = 1'b1;
    cyc(3);
    check("R11 se run", hb_en_o, 4'hF);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule